// File: doc/BRIEF.md
# Condition-Bit Boolean Setter

This execution unit turns one bit of the 32-bit condition register into a 64-bit integer result. It takes a 32-bit instruction word in the X layout and checks that the instruction is one of the four set-boolean operations. It reads a 5-bit bit selector from the instruction and tests that bit of the condition register. It then writes 0 or 1, or 0 or all-ones, to the destination general-purpose register. The result can be the tested bit as is or its complement.

The block decodes and computes with combinational logic only. A parameter adds a single output register stage, so the block can sit at the end of an execute pipeline stage. It never writes the condition register or any carry or overflow state. Its only outputs are a result, a destination index, a write strobe and an illegal-operation flag.

Top module: `cond_bit_setter`

## Requirements
- R1: Instruction fields use LSB-0 positions of `instrWord`. The primary opcode is [31:26] and must equal 31. The destination is [25:21] and appears on `resDest` when writing. The bit selector is [20:16]. The 10-bit extended opcode is [10:1].
- R2: The tested bit is `condReg[31 - sel]`, where sel is the bit selector. Selector 0 tests the most significant bit, which is the first bit of nibble field 0.
- R3: Extended opcode 384 (0b0110000000) gives 1 when the tested bit is set and 0 when it is clear, zero-extended to 64 bits.
- R4: Extended opcode 416 (0b0110100000) gives 0 when the tested bit is set and 1 when it is clear, zero-extended to 64 bits.
- R5: Extended opcode 448 (0b0111000000) gives all-ones when the tested bit is set and 0 when it is clear.
- R6: Extended opcode 480 (0b0111100000) gives 0 when the tested bit is set and all-ones when it is clear.
- R7: With `inValid` high and a primary opcode other than 31, or an extended opcode other than the four above, `resWe` is 0, `resIllegal` is 1, and `resValue` and `resDest` are 0.
- R8: With `inValid` low, `resWe` and `resIllegal` are 0, and `resValue` and `resDest` are 0.
- R9: With OUT_REG=1 (the default), every output shows the inputs of the previous rising clock edge. An active-low reset clears all outputs to 0.
- R10: Instruction bit [0] and the condition-register bits that are not selected have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output stage |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Instruction word is present this cycle |
| instrWord | input | 32 | Instruction word |
| condReg | input | 32 | Condition register contents, LSB-0 |
| resValue | output | 64 | Result for the destination register |
| resDest | output | 5 | Destination register index |
| resWe | output | 1 | Write enable for the destination register |
| resIllegal | output | 1 | Valid word with an unmatched encoding |

## Verification
The bit select and the polarity and width shaping act in the same cycle, so the two can hide each other's faults. A wrong bit index can look right when a wrong inversion flips the result back. The bench therefore sweeps all 32 selectors for each of the four operations against a random condition register, and also repeats each selector with only the selected bit flipped. Every result is compared with a bench model built on the 31-minus-selector mapping. The write and illegal decisions share that cycle too. Random words mixed with near-miss extended opcodes are judged on whether exactly one of the two strobes rises, with a zero result.

// File: rtl/cbs_pkg.sv
package cbs_pkg;
  localparam int XLEN    = 64;
  localparam int CR_W    = 32;
  localparam int INSTR_W = 32;
  localparam int REG_IDX_W = 5;
  localparam int XO_W    = 10;

  localparam logic [5:0]      PRIM_OP    = 6'd31;
  localparam logic [XO_W-1:0] XO_BIT     = 10'd384;
  localparam logic [XO_W-1:0] XO_BIT_REV = 10'd416;
  localparam logic [XO_W-1:0] XO_MSK     = 10'd448;
  localparam logic [XO_W-1:0] XO_MSK_REV = 10'd480;

  typedef struct packed {
    logic doWrite;
    logic flagIllegal;
    logic invert;
    logic wide;
  } setStrobe_t;
endpackage

// File: rtl/cbs_control.sv
module cbs_control
  import cbs_pkg::*;
(
  input  logic                 inValid,
  input  logic [INSTR_W-1:0]   instrWord,
  output setStrobe_t           strb,
  output logic [REG_IDX_W-1:0] rtSel,
  output logic [4:0]           biSel
);
  logic [5:0]      primOp;
  logic [XO_W-1:0] extOp;
  logic            primHit;
  logic            known;
  logic            inv;
  logic            wid;

  assign primOp = instrWord[31:26];
  assign extOp  = instrWord[10:1];
  assign rtSel  = instrWord[25:21];
  assign biSel  = instrWord[20:16];
  assign primHit = (primOp == PRIM_OP);

  always_comb begin
    known = 1'b1;
    inv   = 1'b0;
    wid   = 1'b0;
    unique case (extOp)
      XO_BIT:     begin inv = 1'b0; wid = 1'b0; end
      XO_BIT_REV: begin inv = 1'b1; wid = 1'b0; end
      XO_MSK:     begin inv = 1'b0; wid = 1'b1; end
      XO_MSK_REV: begin inv = 1'b1; wid = 1'b1; end
      default:    known = 1'b0;
    endcase
  end

  always_comb begin
    strb.doWrite     = inValid && primHit && known;
    strb.flagIllegal = inValid && !(primHit && known);
    strb.invert      = inv;
    strb.wide        = wid;
  end
endmodule

// File: rtl/cbs_datapath.sv
module cbs_datapath
  import cbs_pkg::*;
#(
  parameter int OUT_REG = 1
)(
  input  logic                 clk,
  input  logic                 rstN,
  input  setStrobe_t           strb,
  input  logic [CR_W-1:0]      condReg,
  input  logic [4:0]           biSel,
  input  logic [REG_IDX_W-1:0] rtSel,
  output logic [XLEN-1:0]      resValue,
  output logic [REG_IDX_W-1:0] resDest,
  output logic                 resWe,
  output logic                 resIllegal
);
  localparam int BIW = $clog2(CR_W);

  logic                 testBit;
  logic                 outBit;
  logic [XLEN-1:0]      nextValue;
  logic [REG_IDX_W-1:0] nextDest;
  logic [BIW-1:0]       crIdx;

  // selector counts from the most significant end
  assign crIdx   = BIW'(CR_W - 1) - biSel[BIW-1:0];
  assign testBit = condReg[crIdx];
  assign outBit  = testBit ^ strb.invert;

  always_comb begin
    if (!strb.doWrite)
      nextValue = '0;
    else if (strb.wide)
      nextValue = {XLEN{outBit}};
    else
      nextValue = {{(XLEN-1){1'b0}}, outBit};
    nextDest = strb.doWrite ? rtSel : '0;
  end

  generate
    if (OUT_REG != 0) begin : g_reg
      always_ff @(posedge clk) begin
        if (!rstN) begin
          resValue   <= '0;
          resDest    <= '0;
          resWe      <= 1'b0;
          resIllegal <= 1'b0;
        end else begin
          resValue   <= nextValue;
          resDest    <= nextDest;
          resWe      <= strb.doWrite;
          resIllegal <= strb.flagIllegal;
        end
      end
    end else begin : g_comb
      assign resValue   = nextValue;
      assign resDest    = nextDest;
      assign resWe      = strb.doWrite;
      assign resIllegal = strb.flagIllegal;
    end
  endgenerate
endmodule

// File: rtl/cond_bit_setter.sv
module cond_bit_setter
  import cbs_pkg::*;
#(
  parameter int OUT_REG = 1
)(
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  input  logic [31:0] instrWord,
  input  logic [31:0] condReg,
  output logic [63:0] resValue,
  output logic [4:0]  resDest,
  output logic        resWe,
  output logic        resIllegal
);
  setStrobe_t           strb;
  logic [REG_IDX_W-1:0] rtSel;
  logic [4:0]           biSel;

  cbs_control u_ctrl (
    .inValid   (inValid),
    .instrWord (instrWord),
    .strb      (strb),
    .rtSel     (rtSel),
    .biSel     (biSel)
  );

  cbs_datapath #(.OUT_REG(OUT_REG)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .condReg    (condReg),
    .biSel      (biSel),
    .rtSel      (rtSel),
    .resValue   (resValue),
    .resDest    (resDest),
    .resWe      (resWe),
    .resIllegal (resIllegal)
  );
endmodule

// File: rtl/cond_bit_setter_chk.sv
module cond_bit_setter_chk #(
  parameter int OUT_REG = 1
)(
  input logic        clk,
  input logic        rstN,
  input logic        inValid,
  input logic [31:0] instrWord,
  input logic [31:0] condReg,
  input logic [63:0] resValue,
  input logic [4:0]  resDest,
  input logic        resWe,
  input logic        resIllegal
);
  AST_WE_ILLEGAL_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(resWe && resIllegal)); // R7

  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    !resWe |-> (resValue == 64'd0 && resDest == 5'd0)); // R8

  AST_RESULT_SHAPE: assert property (@(posedge clk) disable iff (!rstN)
    resWe |-> (resValue == 64'd0 || resValue == 64'd1 || (&resValue))); // R5

  generate
    if (OUT_REG != 0) begin : g_seq
      AST_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
        (resWe || resIllegal) |-> $past(inValid)); // R9

      AST_PRIMARY: assert property (@(posedge clk) disable iff (!rstN)
        resWe |-> ($past(instrWord[31:26]) == 6'd31)); // R1
    end else begin : g_cmb
      AST_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
        (resWe || resIllegal) |-> inValid); // R9

      AST_PRIMARY: assert property (@(posedge clk) disable iff (!rstN)
        resWe |-> (instrWord[31:26] == 6'd31)); // R1
    end
  endgenerate
endmodule

bind cond_bit_setter cond_bit_setter_chk #(.OUT_REG(OUT_REG)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .inValid    (inValid),
  .instrWord  (instrWord),
  .condReg    (condReg),
  .resValue   (resValue),
  .resDest    (resDest),
  .resWe      (resWe),
  .resIllegal (resIllegal)
);

// File: tb/sim_cond_bit_setter.sv
`timescale 1ns/1ps
module sim_cond_bit_setter;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [31:0] instrWord = '0;
  logic [31:0] condReg = '0;
  logic [63:0] resValue;
  logic [4:0]  resDest;
  logic        resWe;
  logic        resIllegal;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  cond_bit_setter u0 (
    .clk(clk), .rstN(rstN), .inValid(inValid), .instrWord(instrWord),
    .condReg(condReg), .resValue(resValue), .resDest(resDest),
    .resWe(resWe), .resIllegal(resIllegal)
  );

  localparam logic [9:0] XOS [4] = '{10'd384, 10'd416, 10'd448, 10'd480};

  function automatic logic [31:0] mkWord(logic [5:0] p, logic [4:0] rt,
                                         logic [4:0] bi, logic [9:0] xo, logic rc);
    return {p, rt, bi, 5'd0, xo, rc};
  endfunction

  function automatic bit isLegal(logic [31:0] w);
    logic [9:0] xo;
    xo = w[10:1];
    return (w[31:26] == 6'd31) &&
           (xo == 10'd384 || xo == 10'd416 || xo == 10'd448 || xo == 10'd480);
  endfunction

  function automatic logic [63:0] refValue(logic [31:0] w, logic [31:0] cr);
    logic b;
    logic [9:0] xo;
    xo = w[10:1];
    b = cr[31 - int'(w[20:16])];
    case (xo)
      10'd384: return b ? 64'd1 : 64'd0;
      10'd416: return b ? 64'd0 : 64'd1;
      10'd448: return b ? '1 : 64'd0;
      10'd480: return b ? 64'd0 : '1;
      default: return 64'd0;
    endcase
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive at negedge, capture at posedge, sample at following negedge
  task automatic apply(logic v, logic [31:0] w, logic [31:0] cr, string req);
    logic legal;
    inValid = v; instrWord = w; condReg = cr;
    @(posedge clk);
    @(negedge clk);
    legal = v && isLegal(w);
    check(req, resValue, legal ? refValue(w, cr) : 64'd0);
    check(req, {59'd0, resDest}, legal ? {59'd0, w[25:21]} : 64'd0);
    check(req, {63'd0, resWe}, {63'd0, legal});
    check(req, {63'd0, resIllegal}, {63'd0, v && !isLegal(w)});
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] cr;
    logic [31:0] w;
    void'($urandom(32'd7731));
    inValid = 1'b1;
    instrWord = mkWord(6'd31, 5'd3, 5'd0, 10'd448, 1'b0);
    condReg = '1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    // R9 reset clears outputs even with a legal word present
    check("R9 reset", resValue, 64'd0);
    check("R9 reset", {63'd0, resWe}, 64'd0);
    check("R9 reset", {63'd0, resIllegal}, 64'd0);
    rstN = 1'b1;

    // R2 directed: only MSB set, selector 0 must see it, selector 31 must not
    apply(1, mkWord(6'd31, 5'd1, 5'd0, 10'd384, 1'b0), 32'h8000_0000, "R2 msb");
    apply(1, mkWord(6'd31, 5'd1, 5'd31, 10'd384, 1'b0), 32'h8000_0000, "R2 lsb");
    apply(1, mkWord(6'd31, 5'd1, 5'd31, 10'd448, 1'b0), 32'h0000_0001, "R2 lsb set");

    // R3 R4 R5 R6: sweep every selector for each variant, then flip the bit
    for (int k = 0; k < 4; k++) begin
      for (int b = 0; b < 32; b++) begin
        cr = $urandom;
        w = mkWord(6'd31, 5'($urandom), 5'(b), XOS[k], 1'b0);
        case (k)
          0: apply(1, w, cr, "R3 sweep");
          1: apply(1, w, cr, "R4 sweep");
          2: apply(1, w, cr, "R5 sweep");
          default: apply(1, w, cr, "R6 sweep");
        endcase
        apply(1, w, cr ^ (32'h8000_0000 >> b), "R2 flip");
      end
    end

    // R10: Rc bit set and unselected bits toggled give the same result
    for (int i = 0; i < 16; i++) begin
      cr = $urandom;
      w = mkWord(6'd31, 5'($urandom), 5'($urandom), XOS[i % 4], 1'b1);
      apply(1, w, cr, "R10 rc");
      apply(1, w, ~cr ^ (32'h8000_0000 >> w[20:16]), "R10 others");
    end

    // R7: wrong primary opcode, near-miss and random extended opcodes
    apply(1, mkWord(6'd30, 5'd4, 5'd2, 10'd384, 1'b0), '1, "R7 primary");
    apply(1, mkWord(6'd31, 5'd4, 5'd2, 10'd385 - 10'd1 + 10'd128, 1'b0), '1, "R7 xo");
    apply(1, mkWord(6'd31, 5'd4, 5'd2, 10'd400, 1'b0), '1, "R7 xo near");
    apply(1, mkWord(6'd31, 5'd4, 5'd2, 10'd128, 1'b0), '1, "R7 setb-like");
    for (int i = 0; i < 40; i++) begin
      apply(1, $urandom, $urandom, "R7 random");
    end

    // R8: invalid with legal words on the inputs
    for (int i = 0; i < 8; i++) begin
      apply(0, mkWord(6'd31, 5'($urandom), 5'($urandom), XOS[i % 4], 1'b0), $urandom, "R8 idle");
    end

    // R1 R9: back-to-back words, destination follows each one
    for (int i = 0; i < 8; i++) begin
      apply(1, mkWord(6'd31, 5'(i * 3), 5'(i), XOS[i % 4], 1'b0), $urandom, "R1 dest");
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule